// File: doc/BRIEF.md
# Dual-Bank ECC Slice Memory

A local memory for one compute slice, split into two independent banks: a data bank and a weight bank. Every clock cycle it takes at most one full-row write, steered to either bank, and serves one full-row read from each bank at the same time. Rows are never accessed in part.

Each 64-bit word of a row is stored with its own 8-bit single-error-correct, double-error-detect check field. The check field is generated as the row is written, and it is checked and corrected on each read. Each read port returns the corrected row and two flags. The flags are the OR, across all words of the row, of "single error corrected" and "double error detected". A test-only flip mask can invert chosen stored bits as a row is written, so that the error paths can be exercised. Row width, in words, and depth are parameters. Their defaults are small so that a full sweep is cheap in simulation; the full-size configuration is 32 words by 2048 rows.

Top module: `slice_mem_ecc`

## Requirements
- R1: After reset and before any read, both read ports show all-zero data with both error flags low.
- R2: Read data and flags appear on the first rising edge after the read enable and address are sampled. While the port's read enable is low, its outputs hold their last value.
- R3: `wr_bank_i` = 0 writes the data bank and `wr_bank_i` = 1 writes the weight bank. The bank that is not selected keeps its contents.
- R4: Both read ports can read in the same cycle as a write, each from its own bank, with independent addresses.
- R5: When a read and a write hit the same bank and row in one cycle, the read returns the contents from before the write. The new row is returned from the next cycle on.
- R6: A write stores every word of the row, and a clean read returns the row unchanged with both flags low.
- R7: If exactly one stored bit of one word is inverted, the read returns the original data with `*_sec_o` high and `*_ded_o` low. This holds for any of the 72 stored bits of that word, check bits included.
- R8: If two stored bits of the same word are inverted, `*_ded_o` is high and `*_sec_o` is low, unless some other word of the row has a single error.
- R9: The flags of a port are the OR over all words of the row. A row with a single error in one word and a double error in another raises both flags.
- R10: Word w of a row is data bits [64w+63:64w]. Its stored 72-bit codeword is inverted by `inj_flip_i` bits [72w+71:72w], applied only to the write in which the mask is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Row write enable |
| wr_bank_i | input | 1 | Write target: 0 data bank, 1 weight bank |
| wr_addr_i | input | AW | Write row address |
| wr_data_i | input | 64*ROW_WORDS | Full-row write data |
| inj_flip_i | input | 72*ROW_WORDS | Test-only mask of stored bits to invert on this write |
| dat_rd_en_i | input | 1 | Data bank read enable |
| dat_rd_addr_i | input | AW | Data bank read row |
| dat_rd_data_o | output | 64*ROW_WORDS | Corrected data bank row |
| dat_sec_o | output | 1 | Data port: a single error was corrected in some word |
| dat_ded_o | output | 1 | Data port: a double error was detected in some word |
| wgt_rd_en_i | input | 1 | Weight bank read enable |
| wgt_rd_addr_i | input | AW | Weight bank read row |
| wgt_rd_data_o | output | 64*ROW_WORDS | Corrected weight bank row |
| wgt_sec_o | output | 1 | Weight port: a single error was corrected in some word |
| wgt_ded_o | output | 1 | Weight port: a double error was detected in some word |

## Verification
The assertions assume that write controls are never unknown while a write is enabled and that data driven into the encoder is known. The bench drives every input on the falling edge from reset onward, so no unknown ever reaches a sampled control. They also assume that the injection mask is the only source of stored corruption. The bench therefore builds its expected flags from the mask it chose for each row: one inverted bit per word gives a single error, and two inverted bits in one word give a double error. It sweeps every single-bit position of every word, and every bit pair within a word.

// File: rtl/slice_mem_pkg.sv
package slice_mem_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned CW = 72;
  localparam int unsigned PB = 7;

  // Hamming positions 1..71 (check bits at powers of two), bit 0 = overall parity
  function automatic logic [CW-1:0] secded_encode(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    logic          x;
    int unsigned   k;
    c = '0;
    k = 0;
    for (int unsigned p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int unsigned i = 0; i < PB; i++) begin
      x = 1'b0;
      for (int unsigned p = 1; p < CW; p++) if (p[i]) x ^= c[p];
      c[(1 << i)] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [PB-1:0] secded_syndrome(input logic [CW-1:0] c);
    logic [PB-1:0] s;
    s = '0;
    for (int unsigned p = 1; p < CW; p++) if (c[p]) s ^= p[PB-1:0];
    return s;
  endfunction

  function automatic logic [DW-1:0] secded_extract(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int unsigned   k;
    d = '0;
    k = 0;
    for (int unsigned p = 1; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = c[p];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import slice_mem_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] cw_o
);
  assign cw_o = secded_encode(data_i);

  // R6: every fresh codeword must decode clean
  always_comb begin
    if (!$isunknown(data_i)) begin
      a_r6_enc_clean: assert (secded_syndrome(cw_o) == '0 && !(^cw_o));
    end
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import slice_mem_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output logic          sec_o,
  output logic          ded_o
);
  logic [PB-1:0] syn;
  logic          par;
  logic [CW-1:0] fixed;

  always_comb begin
    syn   = secded_syndrome(cw_i);
    par   = ^cw_i;
    fixed = cw_i;
    sec_o = 1'b0;
    ded_o = 1'b0;
    if (par) begin
      if (32'(syn) < CW) begin
        sec_o = 1'b1;
        fixed[syn] = ~cw_i[syn];  // syn==0 flips only the overall parity bit
      end else begin
        ded_o = 1'b1;  // odd weight pointing outside the word
      end
    end else if (syn != '0) begin
      ded_o = 1'b1;
    end
  end

  assign data_o = secded_extract(fixed);

  // R8: a word is never both corrected and uncorrectable
  always_comb begin
    if (!$isunknown(cw_i)) begin
      a_r8_sec_ded_exclusive: assert (!(sec_o && ded_o));
    end
  end
endmodule

// File: rtl/slice_bank.sv
module slice_bank #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ROW_CW = 288,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [ROW_CW-1:0] wcw_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [ROW_CW-1:0] rcw_o
);
  logic [ROW_CW-1:0] mem [DEPTH];
  logic [ROW_CW-1:0] rcw_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wcw_i;
  end

  // read-before-write on a shared row falls out of nonblocking update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rcw_q <= '0;
    else if (re_i) rcw_q <= mem[raddr_i];
  end

  assign rcw_o = rcw_q;
endmodule

// File: rtl/slice_mem_ecc.sv
module slice_mem_ecc
  import slice_mem_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 4,
  parameter int unsigned DEPTH     = 16,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned ROW_BITS = ROW_WORDS * DW,
  localparam int unsigned ROW_CW   = ROW_WORDS * CW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_bank_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [ROW_BITS-1:0] wr_data_i,
  input  logic [ROW_CW-1:0]   inj_flip_i,
  input  logic                dat_rd_en_i,
  input  logic [AW-1:0]       dat_rd_addr_i,
  output logic [ROW_BITS-1:0] dat_rd_data_o,
  output logic                dat_sec_o,
  output logic                dat_ded_o,
  input  logic                wgt_rd_en_i,
  input  logic [AW-1:0]       wgt_rd_addr_i,
  output logic [ROW_BITS-1:0] wgt_rd_data_o,
  output logic                wgt_sec_o,
  output logic                wgt_ded_o
);
  localparam int unsigned NB = 2;

  logic [ROW_CW-1:0]   enc_cw;
  logic [ROW_CW-1:0]   wr_cw;
  logic [NB-1:0]       rd_en;
  logic [AW-1:0]       rd_addr [NB];
  logic [ROW_CW-1:0]   rd_cw   [NB];
  logic [ROW_BITS-1:0] rd_data [NB];
  logic [ROW_WORDS-1:0] sec_w  [NB];
  logic [ROW_WORDS-1:0] ded_w  [NB];

  for (genvar w = 0; w < ROW_WORDS; w++) begin : g_enc
    secded_enc u_enc (
      .data_i (wr_data_i[w*DW +: DW]),
      .cw_o   (enc_cw[w*CW +: CW])
    );
  end

  assign wr_cw      = enc_cw ^ inj_flip_i;
  assign rd_en      = {wgt_rd_en_i, dat_rd_en_i};
  assign rd_addr[0] = dat_rd_addr_i;
  assign rd_addr[1] = wgt_rd_addr_i;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    slice_bank #(.DEPTH(DEPTH), .ROW_CW(ROW_CW)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_bank_i == 1'(b))),
      .waddr_i (wr_addr_i),
      .wcw_i   (wr_cw),
      .re_i    (rd_en[b]),
      .raddr_i (rd_addr[b]),
      .rcw_o   (rd_cw[b])
    );
    for (genvar w = 0; w < ROW_WORDS; w++) begin : g_dec
      secded_dec u_dec (
        .cw_i   (rd_cw[b][w*CW +: CW]),
        .data_o (rd_data[b][w*DW +: DW]),
        .sec_o  (sec_w[b][w]),
        .ded_o  (ded_w[b][w])
      );
    end
  end

  assign dat_rd_data_o = rd_data[0];
  assign dat_sec_o     = |sec_w[0];
  assign dat_ded_o     = |ded_w[0];
  assign wgt_rd_data_o = rd_data[1];
  assign wgt_sec_o     = |sec_w[1];
  assign wgt_ded_o     = |ded_w[1];

  a_r2_dat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_rd_en_i |=> $stable({dat_rd_data_o, dat_sec_o, dat_ded_o}));
  a_r2_wgt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wgt_rd_en_i |=> $stable({wgt_rd_data_o, wgt_sec_o, wgt_ded_o}));
  a_r3_wr_ctrl_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !$isunknown({wr_bank_i, wr_addr_i}));
endmodule

// File: tb/slice_mem_ecc_bench.sv
module slice_mem_ecc_bench;
  localparam int unsigned RW   = 4;
  localparam int unsigned DEP  = 16;
  localparam int unsigned AW   = $clog2(DEP);
  localparam int unsigned RB   = RW * 64;
  localparam int unsigned RC   = RW * 72;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, wr_bank_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [RB-1:0] wr_data_i = '0;
  logic [RC-1:0] inj_flip_i = '0;
  logic dat_rd_en_i = 1'b0, wgt_rd_en_i = 1'b0;
  logic [AW-1:0] dat_rd_addr_i = '0, wgt_rd_addr_i = '0;
  logic [RB-1:0] dat_rd_data_o, wgt_rd_data_o;
  logic dat_sec_o, dat_ded_o, wgt_sec_o, wgt_ded_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  slice_mem_ecc #(.ROW_WORDS(RW), .DEPTH(DEP)) u_slice_mem_ecc (.*);

  function automatic logic [RB-1:0] pat(int b, int r, int salt);
    logic [RB-1:0] v;
    for (int w = 0; w < RW; w++)
      v[w*64 +: 64] = {32'(b * 32'h1111 + r * 32'h0101 + salt + 5),
                       32'((w * 32'h9E37) ^ (r * 13 + salt * 7 + b + 1))};
    return v;
  endfunction

  task automatic chk(string req, logic [RB-1:0] act, logic [RB-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, results are readable at the next falling edge
  task automatic step(bit we, bit wb, int wa, logic [RB-1:0] wd, logic [RC-1:0] fl,
                      bit dre, int dra, bit wre, int wra);
    wr_en_i = we; wr_bank_i = wb; wr_addr_i = AW'(wa); wr_data_i = wd; inj_flip_i = fl;
    dat_rd_en_i = dre; dat_rd_addr_i = AW'(dra);
    wgt_rd_en_i = wre; wgt_rd_addr_i = AW'(wra);
    @(negedge clk_i);
    wr_en_i = 1'b0; dat_rd_en_i = 1'b0; wgt_rd_en_i = 1'b0; inj_flip_i = '0;
  endtask

  task automatic wr(bit b, int a, logic [RB-1:0] d, logic [RC-1:0] fl);
    step(1, b, a, d, fl, 0, 0, 0, 0);
  endtask

  task automatic rd(bit b, int a);
    if (b) step(0, 0, 0, '0, '0, 0, 0, 1, a);
    else   step(0, 0, 0, '0, '0, 1, a, 0, 0);
  endtask

  task automatic chk_port(string req, bit b, logic [RB-1:0] d, bit s, bit e);
    if (b) begin
      chk(req, wgt_rd_data_o, d);
      chk(req, RB'({wgt_sec_o, wgt_ded_o}), RB'({s, e}));
    end else begin
      chk(req, dat_rd_data_o, d);
      chk(req, RB'({dat_sec_o, dat_ded_o}), RB'({s, e}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk_port("R1", 0, '0, 0, 0);
    chk_port("R1", 1, '0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6/R10 fill both banks, sweep every row
    for (int r = 0; r < DEP; r++) begin
      wr(0, r, pat(0, r, 0), '0);
      wr(1, r, pat(1, r, 0), '0);
    end
    for (int r = 0; r < DEP; r++) begin
      step(0, 0, 0, '0, '0, 1, r, 1, DEP - 1 - r);
      chk_port("R6", 0, pat(0, r, 0), 0, 0);
      chk_port("R6", 1, pat(1, DEP - 1 - r, 0), 0, 0);
    end

    // R2 hold while enable low
    rd(0, 4);
    rd(1, 9);
    step(1, 0, 2, pat(0, 2, 3), '0, 0, 7, 0, 7);
    chk_port("R2", 0, pat(0, 4, 0), 0, 0);
    chk_port("R2", 1, pat(1, 9, 0), 0, 0);

    // R3 bank steering: the other bank stays untouched
    wr(1, 6, pat(1, 6, 9), '0);
    step(0, 0, 0, '0, '0, 1, 6, 1, 6);
    chk_port("R3", 0, pat(0, 6, 0), 0, 0);
    chk_port("R3", 1, pat(1, 6, 9), 0, 0);

    // R4 write plus two reads in one cycle, R5 same row returns old
    step(1, 0, 8, pat(0, 8, 4), '0, 1, 8, 1, 3);
    chk_port("R5", 0, pat(0, 8, 0), 0, 0);
    chk_port("R4", 1, pat(1, 3, 0), 0, 0);
    step(1, 1, 3, pat(1, 3, 4), '0, 1, 8, 1, 3);
    chk_port("R5", 0, pat(0, 8, 4), 0, 0);
    chk_port("R5", 1, pat(1, 3, 0), 0, 0);
    rd(1, 3);
    chk_port("R5", 1, pat(1, 3, 4), 0, 0);

    // R7 every single stored bit of every word, alternating banks
    for (int w = 0; w < RW; w++) begin
      for (int k = 0; k < 72; k++) begin
        logic [RC-1:0] m;
        bit b;
        b = 1'((w + k) % 2);
        m = '0; m[w*72 + k] = 1'b1;
        wr(b, 5, pat(b, 5, k), m);
        rd(b, 5);
        chk_port("R7", b, pat(b, 5, k), 1, 0);
      end
    end

    // R8 every bit pair inside one word (word picked from the pair)
    for (int i = 0; i < 72; i++) begin
      for (int j = i + 1; j < 72; j++) begin
        logic [RC-1:0] m;
        int w;
        w = (i + j) % RW;
        m = '0; m[w*72 + i] = 1'b1; m[w*72 + j] = 1'b1;
        wr(0, 11, pat(0, 11, i), m);
        rd(0, 11);
        checks++;
        if (!(dat_ded_o === 1'b1 && dat_sec_o === 1'b0)) begin
          fails++;
          $display("FAIL R8: got sec=%b ded=%b exp sec=0 ded=1 (w%0d bits %0d,%0d)",
                   dat_sec_o, dat_ded_o, w, i, j);
        end
      end
    end

    // R9 single in word 0, double in word 2 -> both flags on weight port
    begin
      logic [RC-1:0] m;
      m = '0; m[13] = 1'b1; m[2*72 + 3] = 1'b1; m[2*72 + 40] = 1'b1;
      wr(1, 12, pat(1, 12, 1), m);
      rd(1, 12);
      checks++;
      if (!(wgt_sec_o === 1'b1 && wgt_ded_o === 1'b1)) begin
        fails++;
        $display("FAIL R9: got sec=%b ded=%b exp sec=1 ded=1", wgt_sec_o, wgt_ded_o);
      end
      // R10 word 0 corrected in its own slice, word 1 and 3 untouched
      chk("R10", RB'(wgt_rd_data_o[63:0]), RB'(pat(1, 12, 1) >> 0) & RB'(64'hFFFF_FFFF_FFFF_FFFF));
      chk("R10", RB'(wgt_rd_data_o[3*64 +: 64]), RB'(pat(1, 12, 1) >> (3*64)));
      // R10 mask applies only to its own write
      wr(1, 12, pat(1, 12, 2), '0);
      rd(1, 12);
      chk_port("R10", 1, pat(1, 12, 2), 0, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule